// File: doc/BRIEF.md
# Multi-Issue Dependence Cross-Check

This block sits at the issue stage of an in-order pipeline that decodes up to `SLOTS` instructions per cycle. Each slot presents a valid bit, an operation kind, two source register indices and one destination register index. In the same cycle the block decides which leading part of the group may leave together. Its outputs are a per-slot issue mask and a count of the valid slots held back. Slots that do not issue stay upstream and are presented again on the next cycle, moved to the front of the group.

A slot is held when any of these is true:
- one of its sources reads a register that an earlier slot of the same group writes;
- one of its sources reads the destination of a load that issued within the last `LU_DEPTH` cycles;
- it would break a per-cycle structural limit.

Every later slot is then held too, so issue stays in program order. Register 0 reads as a constant and never creates a dependence. The block keeps a short registered history of the loads it has issued. It does not read registers, select bypass paths or execute anything.

Top module: `issue_checker`

## Requirements
- R1: While `rst` is high the issue mask is all zeros. The load history is empty on the first cycle after reset, so no slot is held for load-use in that cycle.
- R2: Slot j is held when its `src_a` or `src_b` equals the nonzero `dst` of any valid slot i < j in the same group.
- R3: A source or destination index of 0 never creates a dependence, either within the group or against the load history.
- R4: Kind codes are ALU=0, LOAD=1, STORE=2, MUL=3 and BRANCH=4; the codes 5 to 7 act as ALU. A LOAD that issues with a nonzero `dst` holds any slot whose source equals that `dst`. This holds for the next `LU_DEPTH` cycles (default 1) and ends after them.
- R5: At most one memory operation (LOAD=1 or STORE=2) issues per cycle. A memory slot that follows an earlier valid memory slot of the group is held.
- R6: At most one MUL (code 3) issues per cycle. A MUL slot that follows an earlier valid MUL slot is held.
- R7: A valid BRANCH (code 4) closes the group. No slot after it issues in the same cycle.
- R8: The issue mask is a contiguous prefix starting at slot 0. An invalid slot is never issued, and neither is any slot after it.
- R9: `stall_count` equals the number of valid slots whose mask bit is 0.
- R10: Only loads that actually issue enter the load history. A load that is held causes no load-use stall on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | SLOTS | Slot holds an instruction |
| slot_kind | input | SLOTS x 3 | Operation kind per slot (ALU=0, LOAD=1, STORE=2, MUL=3, BRANCH=4) |
| slot_src_a | input | SLOTS x REG_W | First source register index |
| slot_src_b | input | SLOTS x REG_W | Second source register index |
| slot_dst | input | SLOTS x REG_W | Destination register index, 0 = no write |
| issue_mask | output | SLOTS | Slots that issue this cycle |
| stall_count | output | $clog2(SLOTS+1) | Number of valid slots held back |

## Verification
Two blocking conditions can arise in the same cycle and the block has to resolve both. One is the load-use check against a load issued on the previous cycle. The other is the in-group check or a structural limit for a later slot. The bench provokes this with directed pairs of cycles. A load issues in the first cycle. In the second cycle slot 0 is independent, but a later slot reads the load's destination and also collides with an earlier slot, by register or by kind. Random groups drawn from a small register range make such overlaps frequent. An in-order reference model in the bench, fed the mask it expects, predicts the mask and the count, so the earliest blocking cause decides where the prefix ends.

// File: rtl/issue_pkg.sv
package issue_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        OP_ALU    = 3'd0,
        OP_LOAD   = 3'd1,
        OP_STORE  = 3'd2,
        OP_MUL    = 3'd3,
        OP_BRANCH = 3'd4
    } op_kind_e;

    typedef struct packed {
        logic mem;
        logic ld;
        logic mul;
        logic br;
    } kind_flags_t;

    function automatic kind_flags_t decode_kind(input logic [KIND_W-1:0] k);
        kind_flags_t f;
        f.ld  = (k == OP_LOAD);
        f.mem = (k == OP_LOAD) || (k == OP_STORE);
        f.mul = (k == OP_MUL);
        f.br  = (k == OP_BRANCH);
        return f;
    endfunction

    function automatic logic reads_reg(input logic [7:0] sa, input logic [7:0] sb,
                                       input logic [7:0] r);
        return (r != 8'd0) && ((sa == r) || (sb == r));
    endfunction

endpackage

// File: rtl/pair_dep_check.sv
module pair_dep_check import issue_pkg::*; #(
    parameter int SLOTS = 4,
    parameter int REG_W = 5
) (
    input  logic [SLOTS-1:0]            slot_valid,
    input  logic [SLOTS-1:0][REG_W-1:0] slot_src_a,
    input  logic [SLOTS-1:0][REG_W-1:0] slot_src_b,
    input  logic [SLOTS-1:0][REG_W-1:0] slot_dst,
    output logic [SLOTS-1:0]            raw_block
);
    logic [SLOTS-1:0][SLOTS-1:0] hit;

    for (genvar j = 0; j < SLOTS; j++) begin : g_consumer
        for (genvar i = 0; i < SLOTS; i++) begin : g_producer
            if (i < j) begin : g_cmp
                assign hit[j][i] = slot_valid[i] &&
                    reads_reg(8'(slot_src_a[j]), 8'(slot_src_b[j]), 8'(slot_dst[i]));
            end else begin : g_none
                assign hit[j][i] = 1'b0;
            end
        end
        assign raw_block[j] = |hit[j];
    end

endmodule

// File: rtl/load_use_track.sv
module load_use_track import issue_pkg::*; #(
    parameter int SLOTS    = 4,
    parameter int REG_W    = 5,
    parameter int LU_DEPTH = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SLOTS-1:0]             issue_mask,
    input  logic [SLOTS-1:0][KIND_W-1:0] slot_kind,
    input  logic [SLOTS-1:0][REG_W-1:0]  slot_src_a,
    input  logic [SLOTS-1:0][REG_W-1:0]  slot_src_b,
    input  logic [SLOTS-1:0][REG_W-1:0]  slot_dst,
    output logic [SLOTS-1:0]             lu_block
);
    logic [LU_DEPTH-1:0]            hist_vld;
    logic [LU_DEPTH-1:0][REG_W-1:0] hist_dst;
    logic                           cap_vld;
    logic [REG_W-1:0]               cap_dst;

    always_comb begin
        cap_vld = 1'b0;
        cap_dst = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (issue_mask[s] && decode_kind(slot_kind[s]).ld && slot_dst[s] != '0) begin
                cap_vld = 1'b1;
                cap_dst = slot_dst[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_vld <= '0;
            hist_dst <= '0;
        end else begin
            hist_vld[0] <= cap_vld;
            hist_dst[0] <= cap_dst;
            for (int d = 1; d < LU_DEPTH; d++) begin
                hist_vld[d] <= hist_vld[d-1];
                hist_dst[d] <= hist_dst[d-1];
            end
        end
    end

    always_comb begin
        lu_block = '0;
        for (int s = 0; s < SLOTS; s++) begin
            for (int d = 0; d < LU_DEPTH; d++) begin
                if (hist_vld[d] &&
                    reads_reg(8'(slot_src_a[s]), 8'(slot_src_b[s]), 8'(hist_dst[d])))
                    lu_block[s] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/struct_limit.sv
module struct_limit import issue_pkg::*; #(
    parameter int SLOTS = 4
) (
    input  logic [SLOTS-1:0]             slot_valid,
    input  logic [SLOTS-1:0][KIND_W-1:0] slot_kind,
    output logic [SLOTS-1:0]             struct_block
);
    logic        seen_mem;
    logic        seen_mul;
    logic        seen_br;
    kind_flags_t fl;

    always_comb begin
        seen_mem = 1'b0;
        seen_mul = 1'b0;
        seen_br  = 1'b0;
        fl       = '0;
        for (int j = 0; j < SLOTS; j++) begin
            fl = decode_kind(slot_kind[j]);
            struct_block[j] = (seen_mem && fl.mem) || (seen_mul && fl.mul) || seen_br;
            if (slot_valid[j]) begin
                seen_mem = seen_mem | fl.mem;
                seen_mul = seen_mul | fl.mul;
                seen_br  = seen_br  | fl.br;
            end
        end
    end

endmodule

// File: rtl/prefix_issue.sv
module prefix_issue #(
    parameter int SLOTS = 4,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             rst,
    input  logic [SLOTS-1:0] slot_valid,
    input  logic [SLOTS-1:0] block,
    output logic [SLOTS-1:0] issue_mask,
    output logic [CNT_W-1:0] stall_count
);
    logic run;

    always_comb begin
        run = !rst;
        stall_count = '0;
        for (int j = 0; j < SLOTS; j++) begin
            run = run && slot_valid[j] && !block[j];
            issue_mask[j] = run;
            if (slot_valid[j] && !run)
                stall_count = stall_count + 1'b1;
        end
    end

endmodule

// File: rtl/issue_checker.sv
module issue_checker import issue_pkg::*; #(
    parameter int SLOTS    = 4,
    parameter int REG_W    = 5,
    parameter int LU_DEPTH = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SLOTS-1:0]             slot_valid,
    input  logic [SLOTS-1:0][KIND_W-1:0] slot_kind,
    input  logic [SLOTS-1:0][REG_W-1:0]  slot_src_a,
    input  logic [SLOTS-1:0][REG_W-1:0]  slot_src_b,
    input  logic [SLOTS-1:0][REG_W-1:0]  slot_dst,
    output logic [SLOTS-1:0]             issue_mask,
    output logic [$clog2(SLOTS+1)-1:0]   stall_count
);
    logic [SLOTS-1:0] raw_block;
    logic [SLOTS-1:0] lu_block;
    logic [SLOTS-1:0] struct_block;
    logic [SLOTS-1:0] any_block;

    pair_dep_check #(.SLOTS(SLOTS), .REG_W(REG_W)) u_pair (
        .slot_valid (slot_valid),
        .slot_src_a (slot_src_a),
        .slot_src_b (slot_src_b),
        .slot_dst   (slot_dst),
        .raw_block  (raw_block)
    );

    load_use_track #(.SLOTS(SLOTS), .REG_W(REG_W), .LU_DEPTH(LU_DEPTH)) u_lu (
        .clk        (clk),
        .rst        (rst),
        .issue_mask (issue_mask),
        .slot_kind  (slot_kind),
        .slot_src_a (slot_src_a),
        .slot_src_b (slot_src_b),
        .slot_dst   (slot_dst),
        .lu_block   (lu_block)
    );

    struct_limit #(.SLOTS(SLOTS)) u_struct (
        .slot_valid   (slot_valid),
        .slot_kind    (slot_kind),
        .struct_block (struct_block)
    );

    assign any_block = raw_block | lu_block | struct_block;

    prefix_issue #(.SLOTS(SLOTS)) u_prefix (
        .rst         (rst),
        .slot_valid  (slot_valid),
        .block       (any_block),
        .issue_mask  (issue_mask),
        .stall_count (stall_count)
    );

endmodule

// File: rtl/issue_checker_sva.sv
module issue_checker_sva import issue_pkg::*; #(
    parameter int SLOTS = 4,
    parameter int REG_W = 5
) (
    input logic                         clk,
    input logic                         rst,
    input logic [SLOTS-1:0]             slot_valid,
    input logic [SLOTS-1:0][KIND_W-1:0] slot_kind,
    input logic [SLOTS-1:0][REG_W-1:0]  slot_src_a,
    input logic [SLOTS-1:0][REG_W-1:0]  slot_src_b,
    input logic [SLOTS-1:0][REG_W-1:0]  slot_dst,
    input logic [SLOTS-1:0]             issue_mask,
    input logic [$clog2(SLOTS+1)-1:0]   stall_count
);
    int               mem_issued;
    int               mul_issued;
    logic             ld_now_vld;
    logic [REG_W-1:0] ld_now_dst;

    always_comb begin
        mem_issued = 0;
        mul_issued = 0;
        ld_now_vld = 1'b0;
        ld_now_dst = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (issue_mask[s]) begin
                if (slot_kind[s] == OP_LOAD || slot_kind[s] == OP_STORE) mem_issued++;
                if (slot_kind[s] == OP_MUL) mul_issued++;
                if (slot_kind[s] == OP_LOAD && slot_dst[s] != '0) begin
                    ld_now_vld = 1'b1;
                    ld_now_dst = slot_dst[s];
                end
            end
        end
    end

    p_prefix_r8: assert property (@(posedge clk) disable iff (rst)
        (((issue_mask + 1'b1) & issue_mask) == '0));

    p_valid_only_r8: assert property (@(posedge clk) disable iff (rst)
        ((issue_mask & ~slot_valid) == '0));

    p_one_mem_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_issued <= 1));

    p_one_mul_r6: assert property (@(posedge clk) disable iff (rst)
        (mul_issued <= 1));

    p_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (int'(stall_count) == $countones(slot_valid) - $countones(issue_mask)));

    p_load_use_r4: assert property (@(posedge clk) disable iff (rst)
        ld_now_vld |=> !(issue_mask[0] &&
            (slot_src_a[0] == $past(ld_now_dst) || slot_src_b[0] == $past(ld_now_dst))));

    if (SLOTS > 1) begin : g_pair
        p_raw_r2: assert property (@(posedge clk) disable iff (rst)
            (slot_valid[0] && slot_dst[0] != '0 &&
             (slot_src_a[1] == slot_dst[0] || slot_src_b[1] == slot_dst[0]))
            |-> !issue_mask[1]);
    end

endmodule

bind issue_checker issue_checker_sva #(.SLOTS(SLOTS), .REG_W(REG_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .slot_valid  (slot_valid),
    .slot_kind   (slot_kind),
    .slot_src_a  (slot_src_a),
    .slot_src_b  (slot_src_b),
    .slot_dst    (slot_dst),
    .issue_mask  (issue_mask),
    .stall_count (stall_count)
);

// File: tb/issue_checker_tb_top.sv
`timescale 1ns/1ps
module issue_checker_tb_top;
    localparam int S  = 4;
    localparam int RW = 5;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [S-1:0]       v;
    logic [S-1:0][2:0]  k;
    logic [S-1:0][RW-1:0] a, b, d;
    logic [S-1:0]       mask;
    logic [2:0]         stall;

    int checks   = 0;
    int failures = 0;

    logic           h_vld = 1'b0;
    logic [RW-1:0]  h_dst = '0;

    always #10 clk = ~clk;

    issue_checker #(.SLOTS(S), .REG_W(RW), .LU_DEPTH(1)) dut_i (
        .clk (clk), .rst (rst),
        .slot_valid (v), .slot_kind (k),
        .slot_src_a (a), .slot_src_b (b), .slot_dst (d),
        .issue_mask (mask), .stall_count (stall)
    );

    function automatic logic uses(int j, logic [RW-1:0] r);
        return (r != 0) && (a[j] == r || b[j] == r);
    endfunction

    function automatic void model(output logic [S-1:0] m, output int st);
        logic run = 1'b1;
        logic smem = 1'b0, smul = 1'b0, sbr = 1'b0;
        st = 0;
        for (int j = 0; j < S; j++) begin
            logic blk = 1'b0;
            logic is_mem = (k[j] == 3'd1 || k[j] == 3'd2);
            logic is_mul = (k[j] == 3'd3);
            for (int i = 0; i < j; i++)
                if (v[i] && uses(j, d[i])) blk = 1'b1;
            if (h_vld && uses(j, h_dst)) blk = 1'b1;
            if ((smem && is_mem) || (smul && is_mul) || sbr) blk = 1'b1;
            if (v[j]) begin
                smem |= is_mem;
                smul |= is_mul;
                sbr  |= (k[j] == 3'd4);
            end
            run = run && v[j] && !blk;
            m[j] = run;
            if (v[j] && !run) st++;
        end
    endfunction

    task automatic clear_group();
        v = '0; k = '0; a = '0; b = '0; d = '0;
    endtask

    task automatic set_slot(int s, logic [2:0] kind, int sa, int sb, int dd);
        v[s] = 1'b1; k[s] = kind;
        a[s] = RW'(sa); b[s] = RW'(sb); d[s] = RW'(dd);
    endtask

    task automatic check_cycle(string req);
        logic [S-1:0] em;
        int es;
        #5;
        model(em, es);
        checks++;
        if (mask !== em) begin
            failures++;
            $display("FAIL %s issue_mask act=%b exp=%b", req, mask, em);
        end
        checks++;
        if (int'(stall) != es) begin
            failures++;
            $display("FAIL %s stall_count act=%0d exp=%0d", req, stall, es);
        end
        h_vld = 1'b0;
        h_dst = '0;
        for (int j = 0; j < S; j++)
            if (em[j] && k[j] == 3'd1 && d[j] != 0) begin
                h_vld = 1'b1;
                h_dst = d[j];
            end
    endtask

    // Four independent ALU slots writing 10..13 and reading 20..27.
    task automatic indep_group();
        clear_group();
        for (int s = 0; s < S; s++) set_slot(s, 3'd0, 20 + 2 * s, 21 + 2 * s, 10 + s);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_group();
        // R1: mask held at zero while in reset, even with work presented
        @(negedge clk);
        indep_group();
        set_slot(0, 3'd1, 1, 2, 20);
        #5;
        checks++;
        if (mask !== '0) begin
            failures++;
            $display("FAIL R1 mask in reset act=%b exp=0000", mask);
        end
        @(negedge clk);
        rst = 1'b0;

        // R1: empty history; slot0 reads r20, which the reset-time load would have written
        indep_group();
        check_cycle("R1");

        // R2: slot1 src_a reads slot0 dst
        @(negedge clk); indep_group(); a[1] = 5'd10; check_cycle("R2");
        // R2: slot3 src_b reads slot1 dst
        @(negedge clk); indep_group(); b[3] = 5'd11; check_cycle("R2");
        // R3: register 0 as dst and source never links slots
        @(negedge clk); indep_group(); d[0] = 0; a[1] = 0; b[2] = 0; a[3] = 0;
        check_cycle("R3");

        // R4: load issues, next cycle consumer stalls, following cycle clears
        @(negedge clk); indep_group(); k[0] = 3'd1; d[0] = 5'd7; check_cycle("R4");
        @(negedge clk); indep_group(); b[0] = 5'd7; check_cycle("R4");
        @(negedge clk); indep_group(); b[0] = 5'd7; check_cycle("R4");
        // R3: load to r0 leaves no history
        @(negedge clk); indep_group(); k[0] = 3'd1; d[0] = 0; check_cycle("R3");
        @(negedge clk); indep_group(); a[0] = 0; check_cycle("R3");

        // R10: held load does not enter history
        @(negedge clk); indep_group(); k[1] = 3'd1; d[1] = 5'd9; a[1] = 5'd10; check_cycle("R10");
        @(negedge clk); indep_group(); a[0] = 5'd9; check_cycle("R10");

        // R5: load then store in one group
        @(negedge clk); indep_group(); k[0] = 3'd1; k[1] = 3'd2; check_cycle("R5");
        // R5: single store late in the group is fine, second mem after it held
        @(negedge clk); indep_group(); k[2] = 3'd2; k[3] = 3'd1; check_cycle("R5");
        // R6: two multiplies
        @(negedge clk); indep_group(); k[0] = 3'd3; k[2] = 3'd3; check_cycle("R6");
        // R7: branch in slot1 closes the group
        @(negedge clk); indep_group(); k[1] = 3'd4; check_cycle("R7");
        // R8: invalid slot2 ends the prefix
        @(negedge clk); indep_group(); v[2] = 1'b0; check_cycle("R8");
        // R9: empty group
        @(negedge clk); clear_group(); check_cycle("R9");

        // R4 with R2 in the same cycle: load issues, then slot2 reads it and slot1 reads slot0
        @(negedge clk); indep_group(); k[3] = 3'd1; d[3] = 5'd6; check_cycle("R4");
        @(negedge clk); indep_group(); a[2] = 5'd6; b[1] = 5'd10; check_cycle("R4");

        // Random groups over a small register range (all requirements)
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            clear_group();
            for (int s = 0; s < S; s++) begin
                int r = int'($urandom_range(0, 9));
                v[s] = (r != 0);
                k[s] = 3'($urandom_range(0, 5));
                a[s] = RW'($urandom_range(0, 7));
                b[s] = RW'($urandom_range(0, 7));
                d[s] = RW'($urandom_range(0, 7));
            end
            check_cycle("R2/R4/R5/R6/R7/R8/R9 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule